// File: doc/BRIEF.md
# Vector Operand Source Modifier

This block sits between an operand fetch and a four-lane vector ALU. It takes a four-lane operand vector and a 32-bit source-select word, and produces the vector the ALU actually consumes. First each output lane picks any one of the four input lanes (a swizzle). Then two sign modifiers act on the selected lanes: an absolute-value control clears the sign, and a negate bit in the source word flips the sign of all four lanes together. Lanes are handled as generic sign-magnitude words whose top bit is the sign, so the block never needs to know the number format.

The swizzle field offers only lane selectors: no selector yields a constant zero or one. Negation is all-or-nothing across the vector. The datapath is combinational; a parameter places an output register behind it (default on), which is cleared by an active-low reset.

Top module: `vec_operand_modifier`

## Requirements
- R1: Output lane k (k = 0..3, lane 0 in bits LANE_W-1:0) copies the input lane chosen by its 2-bit selector in the source word: lane 0 at bits 10:9, lane 1 at bits 12:11, lane 2 at bits 14:13, lane 3 at bits 16:15.
- R2: Selector value 0 picks input lane 0 (x), 1 picks lane 1 (y), 2 picks lane 2 (z), 3 picks lane 3 (w); with both modifiers off the selected lane passes unchanged.
- R3: With abs_en high and source bit 17 low, every output lane has its sign bit (top bit) cleared.
- R4: With abs_en high and source bit 17 high, every output lane has its sign bit set, so the result is never positive.
- R5: With abs_en low and source bit 17 high, every output lane's sign bit is the inverse of the selected input lane's sign bit.
- R6: The modifiers act on the lane after selection: the sign applied to output lane k depends only on the lane its selector picks.
- R7: With swizzle field bits 16:9 equal to 8'hE4 and both modifiers off, the output equals the input bit for bit.
- R8: Bits 31:18 and 8:0 of the source word have no effect on the output.
- R9: The magnitude bits (all but the top bit) of every output lane equal those of the selected input lane under every modifier setting.
- R10: With the output register enabled, the output reflects the inputs present at the previous rising clock edge, and reads all zeros while reset is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| opnd_in | input | 4*LANE_W | Operand vector, lane 0 in the low bits |
| src_ctl | input | 32 | Source-select word carrying swizzle (16:9) and negate (17) |
| abs_en | input | 1 | Take the absolute value of every selected lane |
| opnd_out | output | 4*LANE_W | Modified operand vector |

## Verification
Every cycle the assertions compare the registered output with the inputs of the previous cycle: lane 0 magnitude against input lane x when its selector is 0, the identity pass-through, and the sign pattern under abs alone and abs with negate. Lane routing for all 256 swizzle codes, negation alone, the ordering of selection before the modifiers, the indifference to unused control bits, and the reset value are only shown by the bench's sweep, which computes each expected lane arithmetically from the requirements.

// File: rtl/opmod_pkg.sv
package opmod_pkg;

    localparam int NUM_LANES = 4;
    localparam int SEL_W     = 2;
    localparam int SWZ_LSB   = 9;
    localparam int SWZ_W     = NUM_LANES * SEL_W;
    localparam int NEG_POS   = 17;
    localparam logic [SWZ_W-1:0] SWZ_IDENT = 8'hE4;

    typedef logic [SEL_W-1:0] lane_sel_t;

    // lane 0 selector sits in the least significant bits
    typedef struct packed {
        lane_sel_t sel_w;
        lane_sel_t sel_z;
        lane_sel_t sel_y;
        lane_sel_t sel_x;
    } swz_field_t;

    typedef struct packed {
        swz_field_t swz;
        logic       negate;
    } src_mod_t;

    function automatic src_mod_t decode_src(input logic [SWZ_W:0] field);
        src_mod_t d;
        d.swz    = field[SWZ_W-1:0];
        d.negate = field[SWZ_W];
        return d;
    endfunction

endpackage

// File: rtl/opmod_swizzle.sv
module opmod_swizzle
    import opmod_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [NUM_LANES*LANE_W-1:0] vec_i,
    input  swz_field_t                  swz_i,
    output logic [NUM_LANES*LANE_W-1:0] vec_o
);

    localparam int VEC_W = NUM_LANES * LANE_W;

    logic [SWZ_W-1:0] swz_flat;
    assign swz_flat = swz_i;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        lane_sel_t        pick;
        logic [LANE_W-1:0] lane_val;
        assign pick = swz_flat[k*SEL_W +: SEL_W];
        always_comb begin
            lane_val = '0;
            for (int s = 0; s < NUM_LANES; s++) begin
                if (pick == lane_sel_t'(s)) begin
                    lane_val = vec_i[s*LANE_W +: LANE_W];
                end
            end
        end
        assign vec_o[k*LANE_W +: LANE_W] = lane_val;
    end

    logic unused_width;
    assign unused_width = (VEC_W == 0);

endmodule

// File: rtl/opmod_sign.sv
module opmod_sign
    import opmod_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [NUM_LANES*LANE_W-1:0] vec_i,
    input  logic                        abs_i,
    input  logic                        neg_i,
    output logic [NUM_LANES*LANE_W-1:0] vec_o
);

    localparam int MAG_W = LANE_W - 1;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic             sign_in;
        logic             sign_mid;
        logic [MAG_W-1:0] mag;
        assign sign_in  = vec_i[k*LANE_W + MAG_W];
        assign mag      = vec_i[k*LANE_W +: MAG_W];
        // abs first, then negate
        assign sign_mid = sign_in & ~abs_i;
        assign vec_o[k*LANE_W +: LANE_W] = {sign_mid ^ neg_i, mag};
    end

endmodule

// File: rtl/opmod_stage.sv
module opmod_stage #(
    parameter int W       = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end
    end else begin : g_wire
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign q = d;
    end

endmodule

// File: rtl/vec_operand_modifier.sv
module vec_operand_modifier
    import opmod_pkg::*;
#(
    parameter int LANE_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES*LANE_W-1:0] opnd_in,
    input  logic [31:0]                 src_ctl,
    input  logic                        abs_en,
    output logic [NUM_LANES*LANE_W-1:0] opnd_out
);

    localparam int VEC_W = NUM_LANES * LANE_W;

    src_mod_t         mods;
    logic [VEC_W-1:0] swizzled;
    logic [VEC_W-1:0] signed_vec;

    assign mods = decode_src(src_ctl[SWZ_LSB +: SWZ_W+1]);

    logic unused_ctl;
    assign unused_ctl = ^{src_ctl[31:NEG_POS+1], src_ctl[SWZ_LSB-1:0]};

    opmod_swizzle #(.LANE_W(LANE_W)) u_swizzle (
        .vec_i (opnd_in),
        .swz_i (mods.swz),
        .vec_o (swizzled)
    );

    opmod_sign #(.LANE_W(LANE_W)) u_sign (
        .vec_i (swizzled),
        .abs_i (abs_en),
        .neg_i (mods.negate),
        .vec_o (signed_vec)
    );

    opmod_stage #(.W(VEC_W), .REG_OUT(REG_OUT)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (signed_vec),
        .q     (opnd_out)
    );

    if (REG_OUT) begin : g_chk
        logic                 chk_primed;
        logic [NUM_LANES-1:0] out_signs;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chk_primed <= 1'b0;
            else        chk_primed <= 1'b1;
        end

        for (genvar k = 0; k < NUM_LANES; k++) begin : g_sgn
            assign out_signs[k] = opnd_out[k*LANE_W + LANE_W - 1];
        end

        a_r7_identity_pass: assert property (@(posedge clk) disable iff (!rst_n || !chk_primed)
            $past(src_ctl[SWZ_LSB +: SWZ_W] == SWZ_IDENT && !src_ctl[NEG_POS] && !abs_en)
            |-> opnd_out == $past(opnd_in));

        a_r3_abs_clears_sign: assert property (@(posedge clk) disable iff (!rst_n || !chk_primed)
            $past(abs_en && !src_ctl[NEG_POS]) |-> out_signs == '0);

        a_r4_abs_neg_sets_sign: assert property (@(posedge clk) disable iff (!rst_n || !chk_primed)
            $past(abs_en && src_ctl[NEG_POS]) |-> &out_signs);

        a_r9_lane0_magnitude: assert property (@(posedge clk) disable iff (!rst_n || !chk_primed)
            $past(src_ctl[SWZ_LSB +: SEL_W] == '0)
            |-> opnd_out[LANE_W-2:0] == $past(opnd_in[LANE_W-2:0]));
    end

endmodule

// File: tb/vec_operand_modifier_tb.sv
module vec_operand_modifier_tb;

    localparam int LW = 16;
    localparam int VW = 4 * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] opnd_in = '0;
    logic [31:0]   src_ctl = '0;
    logic          abs_en = 1'b0;
    logic [VW-1:0] opnd_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vec_operand_modifier #(.LANE_W(LW), .REG_OUT(1'b1)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opnd_in  (opnd_in),
        .src_ctl  (src_ctl),
        .abs_en   (abs_en),
        .opnd_out (opnd_out)
    );

    function automatic logic [VW-1:0] model(input logic [VW-1:0] d, input logic [31:0] c,
                                           input logic ab);
        logic [VW-1:0] r;
        for (int k = 0; k < 4; k++) begin
            int sel;
            logic [LW-1:0] ln;
            sel = int'((c >> (9 + 2*k)) & 32'h3);
            ln  = LW'(d >> (LW*sel));
            if (ab)    ln[LW-1] = 1'b0;
            if (c[17]) ln[LW-1] = ~ln[LW-1];
            r[k*LW +: LW] = ln;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] exp);
        n_vec++;
        if (opnd_out !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (ctl=%h abs=%0b)", tag, opnd_out, exp,
                     src_ctl, abs_en);
        end
    endtask

    initial begin
        logic [VW-1:0] pats [3];
        logic [VW-1:0] exp_v;
        logic [VW-1:0] old_v;
        pats[0] = {16'hC444, 16'h3333, 16'h8222, 16'h1111};
        pats[1] = {16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF};
        pats[2] = {16'h0FF0, 16'hF00F, 16'h5A5A, 16'hA5A5};

        repeat (3) @(negedge clk);
        opnd_in = pats[0];
        src_ctl = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R10 reset", '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 256; s++) begin
                    logic [31:0] junk;
                    string tag;
                    junk    = (32'(s) * 32'h9E37_79B1) ^ 32'(p * 32'h1357_9BDF + m);
                    junk[17:9] = '0;
                    opnd_in = pats[p];
                    src_ctl = junk | (32'(s) << 9) | (32'(m[1]) << 17);
                    abs_en  = m[0];
                    exp_v   = model(pats[p], src_ctl, abs_en);
                    @(negedge clk);
                    // R6, R8 and R9 are covered by every vector of this sweep
                    if (s == 8'hE4 && m == 0) begin
                        tag = "R7 identity";
                        if (exp_v != pats[p]) n_bad++;
                    end
                    else if (m == 0) tag = "R1 R2 R8 lane select";
                    else if (m == 1) tag = "R3 R6 R9 abs";
                    else if (m == 2) tag = "R5 R6 R9 negate";
                    else             tag = "R4 R6 R9 abs+negate";
                    check(tag, exp_v);
                end
            end
        end

        // R10: one-cycle latency
        opnd_in = pats[2];
        src_ctl = 32'h0000_1C800;
        abs_en  = 1'b0;
        @(negedge clk);
        old_v = model(pats[2], src_ctl, 1'b0);
        opnd_in = pats[1];
        #1;
        check("R10 holds until edge", old_v);
        @(negedge clk);
        check("R10 updates after edge", model(pats[1], src_ctl, 1'b0));

        rst_n = 1'b0;
        #1;
        check("R10 reset clears", '0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule